// File: doc/BRIEF.md
# D-Channel HDLC Frame Transmitter

This block turns bytes that a host has queued into a bit-serial HDLC stream for a signalling channel. The host has a single write port with a one-bit address. Address 0 pushes a byte into a 128-entry transmit queue. Address 1 is a write-only command word whose bits act only when written as one. Framing is automatic. An opening flag goes out before the first byte and the data goes out least significant bit first. A zero is stuffed after every run of five ones. When the host marks the end of a frame, the block appends a 16-bit check sequence and a closing flag. A line-timing strobe paces the serializer, and every emitted bit is presented together with a one-cycle valid strobe.

The host feeds a frame in chunks. On the first load it may queue up to the full 128 bytes. After that it refills in 64-byte portions, each time in answer to a transmit-ready interrupt. If the queue runs dry before the end mark, the frame is aborted with a run of ones and an underrun flag is raised. A transmitter-reset command empties the queue and puts the line straight into an all-ones idle fill.

Top module: `hdlc_dtx`

## Requirements
- R1: After reset, and whenever no frame is in progress, every strobed output bit is 1, `irq_xund` is 0, and during reset `ser_stb` and `irq_xrdy` are 0.
- R2: A frame consists of the flag 0x7E, then the queued bytes, then the check sequence, then a closing 0x7E. Every field is sent least significant bit first.
- R3: Inside the data and check-sequence fields, a 0 is inserted after any five consecutive 1s (including a run that ends the check sequence). Flags are never stuffed.
- R4: The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1. It is preset to all ones and computed over the data bits in line order. Its ones-complement is sent least significant bit first.
- R5: The queue holds 128 bytes and the first load may fill it completely. `irq_xrdy` rises when at least 64 entries are free. It falls in the cycle after a command write with bit 3 (start/continue) set, and it rises again only once 64 entries are free after that write.
- R6: Command word bit positions: bit 0 transmitter reset, bit 1 end of message, bit 3 start/continue. Bits 7, 6, 5, 4 and 2, and any bit written as 0, have no effect on the line or on the interrupts.
- R7: Bits 3 and 1 written together send whatever is queued as a complete frame. With an empty queue this sends a frame with no data: two flags around a check sequence of sixteen zeros.
- R8: Bit 0 empties the queue. From the next strobe on, the line carries ones. `irq_xrdy` is 1 from the following cycle. If bit 0 is written in the same word as bit 3 or bit 1, those other bits are ignored.
- R9: If the queue empties in mid-frame with no end mark, the frame is closed with at least seven consecutive 1s and `irq_xund` rises. A write with bit 3 or bit 0 clears it in the next cycle.
- R10: `ser_stb` is high in exactly the cycles that follow a cycle with `line_tick` high.
- R11: A start/continue write issued after a refill extends the running frame with no gap, so a 192-byte frame queued in a 128-byte and a 64-byte load is sent as one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 1 | 0 = queue byte, 1 = command word |
| wr_data | input | 8 | Write data |
| line_tick | input | 1 | One pulse per line bit period |
| ser_bit | output | 1 | Serial line bit |
| ser_stb | output | 1 | Marks a new value on ser_bit |
| irq_xrdy | output | 1 | Transmit queue can take a 64-byte chunk |
| irq_xund | output | 1 | Frame aborted on queue underrun |

## Verification
Two functions can land in the same command write: a transmitter reset and a frame start or end. The bench provokes this by queuing five bytes and then writing 0x0B. It judges the result by three observations. The line must stay at ones, and `irq_xrdy` must remain set, which a start honoured alone would have cleared. A following start-plus-end write must then produce the empty frame, which proves the queued bytes were discarded. A second overlap is a reset that lands mid-frame while bits are being strobed. There the reference model drops its expected queue at that exact edge and requires only ones afterwards.

// File: rtl/hdlc_dtx_pkg.sv
package hdlc_dtx_pkg;

  localparam logic [7:0]  FLAG_BYTE    = 8'h7E;
  localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;
  localparam int          STUFF_RUN    = 5;

  // command word bit positions
  localparam int CMD_XRST = 0;
  localparam int CMD_XEND = 1;
  localparam int CMD_XGO  = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPEN,
    S_DATA,
    S_FCS,
    S_CLOSE,
    S_ABORT
  } ser_st_e;

endpackage

// File: rtl/hdlc_dtx_crc.sv
module hdlc_dtx_crc #(
  parameter int          W    = 16,
  parameter logic [15:0] POLY = 16'h8408
) (
  input  logic [W-1:0] crc_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);

  logic fb;

  always_comb begin
    fb = crc_i[0] ^ bit_i;
    if (fb) crc_o = (crc_i >> 1) ^ POLY[W-1:0];
    else    crc_o = crc_i >> 1;
  end

endmodule

// File: rtl/hdlc_dtx_fifo.sv
module hdlc_dtx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic [CW-1:0] fill
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];
  assign fill    = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp_q] <= din;
  end

endmodule

// File: rtl/hdlc_dtx_ser.sv
module hdlc_dtx_ser
  import hdlc_dtx_pkg::*;
#(
  parameter int  DW    = 8,
  parameter int  CRC_W = 16,
  localparam int SHW   = CRC_W,
  localparam int CNTW  = $clog2(SHW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          go,
  input  logic          end_pend,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  output logic          fifo_pop,
  output logic          ser_bit,
  output logic          ser_stb,
  output logic          frame_done,
  output logic          abort_done
);

  localparam logic [CNTW-1:0] BYTE_LAST = CNTW'(DW - 1);
  localparam logic [CNTW-1:0] FCS_LAST  = CNTW'(CRC_W - 1);

  ser_st_e          st_q, st_d;
  logic [SHW-1:0]   sh_q, sh_d;
  logic [CNTW-1:0]  cnt_q, cnt_d;
  logic [2:0]       ones_q, ones_d;
  logic [CRC_W-1:0] crc_q, crc_d, crc_nx, seed;
  logic             bit_q, bit_d, stb_q, stb_d;
  logic             cur, stuff, need_load;

  assign cur   = sh_q[cnt_q];
  assign stuff = (ones_q == 3'(STUFF_RUN)) &&
                 ((st_q == S_DATA) || (st_q == S_FCS) ||
                  ((st_q == S_CLOSE) && (cnt_q == '0)));

  hdlc_dtx_crc #(.W(CRC_W), .POLY(CRC_POLY_REV)) u_crc (
    .crc_i (crc_q),
    .bit_i (cur),
    .crc_o (crc_nx)
  );

  always_comb begin
    st_d       = st_q;
    sh_d       = sh_q;
    cnt_d      = cnt_q;
    ones_d     = ones_q;
    crc_d      = crc_q;
    bit_d      = bit_q;
    stb_d      = tick;
    fifo_pop   = 1'b0;
    frame_done = 1'b0;
    abort_done = 1'b0;
    need_load  = 1'b0;
    seed       = crc_q;
    if (clr) begin
      st_d   = S_IDLE;
      cnt_d  = '0;
      ones_d = '0;
      bit_d  = 1'b1;
    end else if (tick) begin
      if (stuff) begin
        bit_d  = 1'b0;
        ones_d = '0;
      end else begin
        unique case (st_q)
          S_IDLE: begin
            bit_d = 1'b1;
            if (go) begin
              st_d  = S_OPEN;
              sh_d  = SHW'(FLAG_BYTE);
              cnt_d = '0;
            end
          end
          S_OPEN: begin
            bit_d  = cur;
            ones_d = '0;
            cnt_d  = cnt_q + CNTW'(1);
            if (cnt_q == BYTE_LAST) begin
              need_load = 1'b1;
              seed      = CRC_PRESET[CRC_W-1:0];
            end
          end
          S_DATA: begin
            bit_d  = cur;
            ones_d = cur ? ones_q + 3'd1 : 3'd0;
            crc_d  = crc_nx;
            cnt_d  = cnt_q + CNTW'(1);
            if (cnt_q == BYTE_LAST) begin
              need_load = 1'b1;
              seed      = crc_nx;
            end
          end
          S_FCS: begin
            bit_d  = cur;
            ones_d = cur ? ones_q + 3'd1 : 3'd0;
            cnt_d  = cnt_q + CNTW'(1);
            if (cnt_q == FCS_LAST) begin
              st_d  = S_CLOSE;
              sh_d  = SHW'(FLAG_BYTE);
              cnt_d = '0;
            end
          end
          S_CLOSE: begin
            bit_d  = cur;
            ones_d = '0;
            cnt_d  = cnt_q + CNTW'(1);
            if (cnt_q == BYTE_LAST) begin
              st_d       = S_IDLE;
              cnt_d      = '0;
              frame_done = 1'b1;
            end
          end
          S_ABORT: begin
            bit_d = 1'b1;
            cnt_d = cnt_q + CNTW'(1);
            if (cnt_q == BYTE_LAST) begin
              st_d       = S_IDLE;
              cnt_d      = '0;
              abort_done = 1'b1;
            end
          end
          default: st_d = S_IDLE;
        endcase
        if (need_load) begin
          cnt_d = '0;
          crc_d = seed;
          if (!fifo_empty) begin
            fifo_pop = 1'b1;
            sh_d     = SHW'(fifo_data);
            st_d     = S_DATA;
          end else if (end_pend) begin
            sh_d = ~seed;
            st_d = S_FCS;
          end else begin
            st_d = S_ABORT;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      ones_q <= '0;
      crc_q  <= CRC_PRESET[CRC_W-1:0];
      bit_q  <= 1'b1;
      stb_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      ones_q <= ones_d;
      crc_q  <= crc_d;
      bit_q  <= bit_d;
      stb_q  <= stb_d;
    end
  end

  assign ser_bit = bit_q;
  assign ser_stb = stb_q;

endmodule

// File: rtl/hdlc_dtx.sv
module hdlc_dtx
  import hdlc_dtx_pkg::*;
#(
  parameter int  DEPTH = 128,
  parameter int  CHUNK = 64,
  parameter int  DW    = 8,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          line_tick,
  output logic          ser_bit,
  output logic          ser_stb,
  output logic          irq_xrdy,
  output logic          irq_xund
);

  logic [1:0]    rst_sync_q;
  logic          rst_s_n;
  logic          cmd_wr, cmd_xrst, cmd_xgo, cmd_xend, data_wr;
  logic          fifo_empty, fifo_pop;
  logic [DW-1:0] fifo_dout;
  logic [CW-1:0] fifo_fill;
  logic          room_ok, go;
  logic          ser_done, ser_abrt;
  logic          start_q, start_d, end_q, end_d;
  logic          und_q, und_d, rdy_q, rdy_d, arm_q, arm_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign cmd_wr   = wr_en && wr_addr;
  assign data_wr  = wr_en && !wr_addr;
  assign cmd_xrst = cmd_wr && wr_data[CMD_XRST];
  assign cmd_xgo  = cmd_wr && wr_data[CMD_XGO]  && !wr_data[CMD_XRST];
  assign cmd_xend = cmd_wr && wr_data[CMD_XEND] && !wr_data[CMD_XRST];

  assign room_ok = (CW'(DEPTH) - fifo_fill) >= CW'(CHUNK);
  assign go      = start_q && (!fifo_empty || end_q);

  hdlc_dtx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_s_n),
    .clr   (cmd_xrst),
    .push  (data_wr),
    .din   (wr_data),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .empty (fifo_empty),
    .fill  (fifo_fill)
  );

  hdlc_dtx_ser #(.DW(DW), .CRC_W(16)) u_ser (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .clr        (cmd_xrst),
    .tick       (line_tick),
    .go         (go),
    .end_pend   (end_q),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_dout),
    .fifo_pop   (fifo_pop),
    .ser_bit    (ser_bit),
    .ser_stb    (ser_stb),
    .frame_done (ser_done),
    .abort_done (ser_abrt)
  );

  always_comb begin
    start_d = start_q;
    end_d   = end_q;
    und_d   = und_q;
    rdy_d   = rdy_q;
    arm_d   = arm_q;
    if (ser_done || ser_abrt) begin
      start_d = 1'b0;
      end_d   = 1'b0;
    end
    if (ser_abrt) und_d = 1'b1;
    if (cmd_xgo) begin
      start_d = 1'b1;
      und_d   = 1'b0;
      rdy_d   = 1'b0;
      arm_d   = 1'b1;
    end else if (arm_q && room_ok) begin
      rdy_d = 1'b1;
      arm_d = 1'b0;
    end
    if (cmd_xend) end_d = 1'b1;
    if (cmd_xrst) begin
      start_d = 1'b0;
      end_d   = 1'b0;
      und_d   = 1'b0;
      rdy_d   = 1'b1;
      arm_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      start_q <= 1'b0;
      end_q   <= 1'b0;
      und_q   <= 1'b0;
      rdy_q   <= 1'b0;
      arm_q   <= 1'b1;
    end else begin
      start_q <= start_d;
      end_q   <= end_d;
      und_q   <= und_d;
      rdy_q   <= rdy_d;
      arm_q   <= arm_d;
    end
  end

  assign irq_xrdy = rdy_q;
  assign irq_xund = und_q;

endmodule

// File: rtl/hdlc_dtx_chk.sv
module hdlc_dtx_chk #(
  parameter int  DEPTH = 128,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_addr,
  input logic          wr_xgo,
  input logic          wr_xrst,
  input logic          line_tick,
  input logic          ser_bit,
  input logic          ser_stb,
  input logic          irq_xrdy,
  input logic          irq_xund,
  input logic [CW-1:0] fill
);

  logic is_rst, is_go;
  assign is_rst = wr_en && wr_addr && wr_xrst;
  assign is_go  = wr_en && wr_addr && wr_xgo && !wr_xrst;

  p_stb_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick |=> ser_stb);

  p_stb_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !line_tick |=> !ser_stb);

  p_reset_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_rst |=> (!ser_stb || ser_bit));

  p_reset_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_rst |=> irq_xrdy);

  p_go_clears_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_go |=> !irq_xrdy);

  p_und_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_go || is_rst) |=> !irq_xund);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

endmodule

bind hdlc_dtx hdlc_dtx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_xgo    (wr_data[3]),
  .wr_xrst   (wr_data[0]),
  .line_tick (line_tick),
  .ser_bit   (ser_bit),
  .ser_stb   (ser_stb),
  .irq_xrdy  (irq_xrdy),
  .irq_xund  (irq_xund),
  .fill      (fifo_fill)
);

// File: tb/tb_hdlc_dtx.sv
`timescale 1ns/1ps
module tb_hdlc_dtx;

  localparam int HUNT_MAX = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       line_tick = 1'b0;
  logic       ser_bit, ser_stb, irq_xrdy, irq_xund;

  always #10 clk = ~clk;

  hdlc_dtx dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .line_tick (line_tick),
    .ser_bit   (ser_bit),
    .ser_stb   (ser_stb),
    .irq_xrdy  (irq_xrdy),
    .irq_xund  (irq_xund)
  );

  int         n_cmp = 0;
  int         n_bad = 0;
  bit         exp_q[$];
  bit         hunting = 1'b0;
  int         hunt_ones = 0;
  bit         mon_on = 1'b0;
  logic [7:0] fr_q[$];
  int         tcnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // line pacing: one tick every four clocks
  initial begin
    forever begin
      @(negedge clk);
      #1;
      line_tick = (tcnt == 0);
      tcnt = (tcnt + 1) % 4;
    end
  end

  // reference model compared on every clock
  always @(negedge clk) begin : mon
    bit b;
    if (mon_on) begin
      chk(ser_stb == line_tick, "R10 strobe follows tick", ser_stb, line_tick);
      if (ser_stb) begin
        if (exp_q.size() == 0) begin
          chk(ser_bit == 1'b1, "R1 idle fill", ser_bit, 1);
        end else if (hunting) begin
          if (ser_bit == 1'b0) begin
            chk(exp_q[0] == 1'b0, "R2 opening flag", 0, exp_q[0]);
            void'(exp_q.pop_front());
            hunting = 1'b0;
          end else begin
            hunt_ones++;
            if (hunt_ones > HUNT_MAX) begin
              chk(1'b0, "R7 frame start", hunt_ones, HUNT_MAX);
              exp_q.delete();
              hunting = 1'b0;
            end
          end
        end else begin
          b = exp_q.pop_front();
          chk(ser_bit == b, "R2/R3/R4 serial bit", ser_bit, b);
        end
      end
    end
  end

  task automatic wr(input bit a, input logic [7:0] v);
    @(negedge clk);
    #1;
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = v;
    @(posedge clk);
    #1;
    if (a && v[0]) begin
      exp_q.delete();
      hunting = 1'b0;
    end
    wr_en = 1'b0;
  endtask

  task automatic load_bytes(input int from, input int upto);
    for (int i = from; i < upto; i++) wr(1'b0, fr_q[i]);
  endtask

  task automatic frame_expect(input bit closed);
    bit          raw[$];
    bit          st[$];
    logic [15:0] c;
    int          ones;
    c = 16'hFFFF;
    foreach (fr_q[i]) begin
      for (int k = 0; k < 8; k++) begin
        bit b;
        b = fr_q[i][k];
        raw.push_back(b);
        if (c[0] ^ b) c = (c >> 1) ^ 16'h8408;
        else          c = c >> 1;
      end
    end
    if (closed) for (int k = 0; k < 16; k++) raw.push_back(~c[k]);
    for (int k = 0; k < 8; k++) st.push_back(k != 0 && k != 7);
    ones = 0;
    foreach (raw[j]) begin
      if (ones == 5) begin
        st.push_back(1'b0);
        ones = 0;
      end
      st.push_back(raw[j]);
      ones = raw[j] ? ones + 1 : 0;
    end
    if (closed) begin
      if (ones == 5) st.push_back(1'b0);
      for (int k = 0; k < 8; k++) st.push_back(k != 0 && k != 7);
    end else begin
      for (int k = 0; k < 7; k++) st.push_back(1'b1);
    end
    foreach (st[j]) exp_q.push_back(st[j]);
    hunting = 1'b1;
    hunt_ones = 0;
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!line_tick) @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R7 watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int w;
    repeat (4) @(negedge clk);
    chk(ser_stb == 1'b0, "R1 reset strobe", ser_stb, 0);
    chk(irq_xrdy == 1'b0, "R1 reset ready irq", irq_xrdy, 0);
    chk(irq_xund == 1'b0, "R1 reset underrun", irq_xund, 0);
    #1 rst_n = 1'b1;
    repeat (6) @(negedge clk);
    mon_on = 1'b1;
    chk(irq_xrdy == 1'b1, "R5 ready after reset", irq_xrdy, 1);
    chk(irq_xund == 1'b0, "R1 no underrun after reset", irq_xund, 0);
    wait_ticks(20);

    // short frame with a stuffed 0xFF and a 0x7E data byte
    fr_q = '{8'h01, 8'h02, 8'hFF, 8'h7E};
    load_bytes(0, fr_q.size());
    frame_expect(1'b1);
    wr(1'b1, 8'h0A);
    chk(irq_xrdy == 1'b0, "R5 start clears ready", irq_xrdy, 0);
    wait_done();
    chk(irq_xrdy == 1'b1, "R5 ready re-armed", irq_xrdy, 1);
    chk(irq_xund == 1'b0, "R7 complete frame no underrun", irq_xund, 0);

    // ones-heavy frame, with command bits 7,6,4 set alongside
    fr_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h3F};
    load_bytes(0, fr_q.size());
    frame_expect(1'b1);
    wr(1'b1, 8'hDA);
    wait_done();

    // bits that must not act
    wr(1'b1, 8'hD4);
    wr(1'b1, 8'h00);
    wait_ticks(30);
    chk(irq_xrdy == 1'b1, "R6 ignored bits keep ready", irq_xrdy, 1);
    chk(irq_xund == 1'b0, "R6 ignored bits keep underrun", irq_xund, 0);

    // 192-byte frame: 128-byte first load, 64-byte refill
    fr_q.delete();
    for (int i = 0; i < 192; i++) fr_q.push_back(8'((i * 37 + 5) % 256));
    load_bytes(0, 128);
    frame_expect(1'b1);
    wr(1'b1, 8'h08);
    chk(irq_xrdy == 1'b0, "R5 full queue no ready", irq_xrdy, 0);
    w = 0;
    while (!irq_xrdy && w < 20000) begin
      @(negedge clk);
      w++;
    end
    chk(irq_xrdy == 1'b1, "R11 ready after chunk drained", irq_xrdy, 1);
    chk(exp_q.size() > 0, "R11 frame still running at refill", exp_q.size(), 1);
    load_bytes(128, 192);
    wr(1'b1, 8'h0A);
    wait_done();
    chk(irq_xund == 1'b0, "R11 refilled frame no underrun", irq_xund, 0);

    // underrun abort
    fr_q = '{8'h12, 8'h34, 8'h56};
    load_bytes(0, fr_q.size());
    frame_expect(1'b0);
    wr(1'b1, 8'h08);
    wait_done();
    chk(irq_xund == 1'b1, "R9 underrun raised", irq_xund, 1);
    wr(1'b1, 8'h08);
    chk(irq_xund == 1'b0, "R9 start clears underrun", irq_xund, 0);
    wr(1'b1, 8'h01);
    chk(irq_xrdy == 1'b1, "R8 reset raises ready", irq_xrdy, 1);
    wait_ticks(20);

    // reset in mid-frame
    fr_q.delete();
    for (int i = 0; i < 20; i++) fr_q.push_back(8'(8'hA5 + i));
    load_bytes(0, fr_q.size());
    frame_expect(1'b1);
    wr(1'b1, 8'h0A);
    wait_ticks(60);
    chk(exp_q.size() > 0, "R8 frame in flight before reset", exp_q.size(), 1);
    wr(1'b1, 8'h01);
    chk(irq_xrdy == 1'b1, "R8 reset mid-frame ready", irq_xrdy, 1);
    wait_ticks(40);
    chk(irq_xund == 1'b0, "R8 reset no underrun", irq_xund, 0);

    // reset together with start and end: start/end ignored, queue emptied
    fr_q = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    load_bytes(0, fr_q.size());
    wr(1'b1, 8'h0B);
    chk(irq_xrdy == 1'b1, "R8 reset wins over start", irq_xrdy, 1);
    wait_ticks(60);
    fr_q.delete();
    frame_expect(1'b1);
    wr(1'b1, 8'h0A);
    wait_done();
    chk(irq_xund == 1'b0, "R7 empty frame no underrun", irq_xund, 0);

    summary();
    $finish;
  end

endmodule